// File: doc/BRIEF.md
# Line-Coalescing Write Buffer

This block sits between a core's store path and the memory side. Each accepted store carries one data word and a byte-enable vector. The buffer groups stores by cache line. The first store to a line opens an entry. Every later store to that line merges into the same entry, byte by byte, even when stores to other lines arrived in between. The memory side receives each entry as one line-sized write: a line address, the full line of data and a per-byte mask. Memory therefore sees fewer transactions. It may also see them in an order other than program order, which is the relaxed store ordering this block is meant to provide.

Entries leave in allocation order. A controller with four named states decides when they leave:
- **FILL**: the buffer accepts stores and presents nothing.
- **DRAIN**: entered from FILL once every entry is occupied. The buffer presents the oldest entry and returns to FILL after one line handshake.
- **FLUSH**: entered from FILL or from DRAIN (after its handshake) when a flush is pending. The buffer presents entries oldest first until none remain, and stores are refused.
- **DONE**: a one-cycle state that raises the flush-complete pulse and then returns to FILL.

While an entry is on the output, it is locked against merges.

Top module: `wbuf_coalesce`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `ln_valid` is 0 and `flush_done` is 0.
- R2: A store whose line tag (`st_addr` bits above the line offset) matches an unlocked buffered entry is merged into that entry and uses no new entry, so the two stores leave as a single line write.
- R3: A line write's mask holds exactly the bytes written since its entry opened. Where two stores hit the same byte, the later data wins. Bytes never written carry data 0 and mask 0.
- R4: A store's word index is `st_addr[4:2]` (default sizes) and its enable bit b selects line byte 4*index+b. Line byte k sits at `ln_data[8k+7:8k]` and `ln_mask[k]`. `ln_addr` is the line tag.
- R5: With no flush pending, `ln_valid` rises in the second cycle after the buffer's last free entry is taken. The oldest entry is presented, and after one handshake the buffer returns to FILL.
- R6: Given stores X, Y, Z where X and Z share a line and Y does not, the merged X/Z line write reaches memory before Y's.
- R7: A store to a line with no unlocked entry stalls (`st_ready` 0) while all entries are occupied. A store that hits an unlocked entry is still accepted when the buffer is full.
- R8: A store to the line currently presented on the output is not merged into it. It stalls while the buffer is full and, once an entry frees, opens a new entry that leaves later.
- R9: Once `ln_valid` is high it stays high, with address, data and mask unchanged, until `ln_ready` is sampled high.
- R10: A flush refuses stores and drains every entry oldest first. `flush_done` is then high for exactly one cycle, in the cycle after the last handshake, or two cycles after the request when the buffer was already empty.
- R11: A flush requested while a capacity drain waits for `ln_ready` is remembered and carried out right after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high together with `st_valid` |
| st_addr | input | ADDR_W | Store byte address; low byte-offset bits are ignored |
| st_data | input | DATA_W | Store data word |
| st_strb | input | DATA_W/8 | Byte enables of the store word |
| ln_valid | output | 1 | Line write valid |
| ln_ready | input | 1 | Memory side accepts the line write |
| ln_addr | output | ADDR_W-log2(LINE_BYTES) | Line tag of the write |
| ln_data | output | LINE_BYTES*8 | Full line data |
| ln_mask | output | LINE_BYTES | Per-byte write mask |
| flush_req | input | 1 | One-cycle request to drain the whole buffer |
| flush_done | output | 1 | One-cycle pulse: buffer empty after a flush |

## Verification
The hardest case to reach is a store aimed at the very line being presented while the buffer is full. That is the only time the head lock decides the outcome instead of the capacity check. The stimulus reaches it by holding `ln_ready` low while four distinct lines fill the buffer, then offering a store to the head line during the capacity drain, then offering a merge into a non-head entry. The same stall is used to place a flush request inside a pending drain. A long run with random lines, byte enables, back-pressure and flushes is compared every cycle against a behavioural queue model.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    // Controller states of the coalescing write buffer
    typedef enum logic [1:0] {
        WB_FILL  = 2'd0,
        WB_DRAIN = 2'd1,
        WB_FLUSH = 2'd2,
        WB_DONE  = 2'd3
    } wb_state_e;
endpackage

// File: rtl/wbuf_slot.sv
// One buffer entry: line tag, full line data and per-byte mask.
module wbuf_slot #(
    parameter int TAG_W      = 27,
    parameter int LINE_BYTES = 32,
    parameter int STRB_W     = 4,
    parameter int WIDX_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    input  logic                    merge_i,
    input  logic                    release_i,
    input  logic [TAG_W-1:0]        tag_i,
    input  logic [WIDX_W-1:0]       widx_i,
    input  logic [STRB_W*8-1:0]     data_i,
    input  logic [STRB_W-1:0]       strb_i,
    output logic                    vld_o,
    output logic [TAG_W-1:0]        tag_o,
    output logic [LINE_BYTES*8-1:0] line_o,
    output logic [LINE_BYTES-1:0]   mask_o
);
    localparam int LINE_W = LINE_BYTES * 8;

    logic [LINE_BYTES-1:0] lane_sel;
    logic [LINE_W-1:0]     lane_val;
    logic [LINE_W-1:0]     line_d;
    logic [LINE_BYTES-1:0] mask_d;

    // Spread the store word over the line: byte k belongs to word k/STRB_W
    always_comb begin
        for (int k = 0; k < LINE_BYTES; k++) begin
            lane_sel[k]        = (widx_i == WIDX_W'(k / STRB_W)) && strb_i[k % STRB_W];
            lane_val[k*8 +: 8] = data_i[(k % STRB_W)*8 +: 8];
        end
    end

    // New contents: a fresh entry starts from zero, a merge keeps old bytes
    always_comb begin
        for (int k = 0; k < LINE_BYTES; k++) begin
            line_d[k*8 +: 8] = lane_sel[k] ? lane_val[k*8 +: 8]
                             : (alloc_i ? 8'h00 : line_o[k*8 +: 8]);
        end
        mask_d = lane_sel | (alloc_i ? '0 : mask_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            tag_o  <= '0;
            line_o <= '0;
            mask_o <= '0;
        end else if (alloc_i) begin
            vld_o  <= 1'b1;
            tag_o  <= tag_i;
            line_o <= line_d;
            mask_o <= mask_d;
        end else begin
            if (merge_i) begin
                line_o <= line_d;
                mask_o <= mask_d;
            end
            if (release_i) begin
                vld_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wbuf_tagmatch.sv
// Parallel tag compare against every unlocked, occupied entry.
module wbuf_tagmatch #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 27
) (
    input  logic [ENTRIES-1:0]            vld_i,
    input  logic [ENTRIES-1:0]            lock_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]              tag_q_i,
    output logic [ENTRIES-1:0]            hit_vec_o,
    output logic                          hit_o
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec_o[i] = vld_i[i] && !lock_i[i] && (tags_i[i] == tag_q_i);
    end
    assign hit_o = |hit_vec_o;
endmodule

// File: rtl/wbuf_ctrl.sv
// Controller: state machine, allocation order pointers and occupancy.
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PTR_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             st_hit,
    input  logic             flush_req,
    input  logic             ln_ready,
    output logic             st_ready,
    output logic             ln_valid,
    output logic             flush_done,
    output logic             do_alloc,
    output logic             do_merge,
    output logic             do_pop,
    output logic [PTR_W-1:0] head_q,
    output logic [PTR_W-1:0] tail_q,
    output logic [CNT_W-1:0] occ_q
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(ENTRIES - 1);

    wb_state_e state_q, state_d;
    logic      pend_q;
    logic      full, empty, accept, flush_seen;

    assign full       = (occ_q == FULL_CNT);
    assign empty      = (occ_q == '0);
    assign flush_seen = flush_req || pend_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WB_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_FILL: begin
                if (flush_seen)  state_d = WB_FLUSH;
                else if (full)   state_d = WB_DRAIN;
            end
            WB_DRAIN: begin
                if (do_pop) state_d = flush_seen ? WB_FLUSH : WB_FILL;
            end
            WB_FLUSH: begin
                if (empty || (do_pop && occ_q == CNT_W'(1))) state_d = WB_DONE;
            end
            WB_DONE: state_d = WB_FILL;
            default: state_d = WB_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        st_ready   = 1'b0;
        ln_valid   = 1'b0;
        flush_done = 1'b0;
        unique case (state_q)
            WB_FILL:  st_ready = st_hit || !full;
            WB_DRAIN: begin
                st_ready = st_hit || !full;
                ln_valid = 1'b1;
            end
            WB_FLUSH: ln_valid = !empty;
            WB_DONE:  flush_done = 1'b1;
            default:  st_ready = 1'b0;
        endcase
    end

    assign accept   = st_valid && st_ready;
    assign do_merge = accept && st_hit;
    assign do_alloc = accept && !st_hit;
    assign do_pop   = ln_valid && ln_ready;

    // Pending flush, head/tail pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (state_q == WB_DONE) pend_q <= 1'b0;
            else if (flush_req)     pend_q <= 1'b1;
            if (do_pop)   head_q <= ptr_next(head_q);
            if (do_alloc) tail_q <= ptr_next(tail_q);
            unique case ({do_alloc, do_pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end
endmodule

// File: rtl/wbuf_coalesce.sv
// Top: line-coalescing write buffer.
module wbuf_coalesce
    import wbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int ENTRIES    = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   st_valid,
    output logic                                   st_ready,
    input  logic [ADDR_W-1:0]                      st_addr,
    input  logic [DATA_W-1:0]                      st_data,
    input  logic [DATA_W/8-1:0]                    st_strb,
    output logic                                   ln_valid,
    input  logic                                   ln_ready,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   ln_addr,
    output logic [LINE_BYTES*8-1:0]                ln_data,
    output logic [LINE_BYTES-1:0]                  ln_mask,
    input  logic                                   flush_req,
    output logic                                   flush_done
);
    localparam int STRB_W = DATA_W / 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BOFF_W = $clog2(STRB_W);
    localparam int WIDX_W = OFF_W - BOFF_W;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W  = $clog2(ENTRIES + 1);

    logic [TAG_W-1:0]  st_tag;
    logic [WIDX_W-1:0] st_widx;
    logic              unused_lo;

    assign st_tag    = st_addr[ADDR_W-1:OFF_W];
    assign st_widx   = st_addr[OFF_W-1:BOFF_W];
    assign unused_lo = ^st_addr[BOFF_W-1:0];

    logic [ENTRIES-1:0]            slot_vld;
    logic [ENTRIES-1:0][TAG_W-1:0] slot_tag;
    logic [ENTRIES-1:0][LINE_W-1:0] slot_line;
    logic [ENTRIES-1:0][LINE_BYTES-1:0] slot_mask;
    logic [ENTRIES-1:0]            lock_vec;
    logic [ENTRIES-1:0]            hit_vec;
    logic                          st_hit;
    logic                          do_alloc, do_merge, do_pop;
    logic [PTR_W-1:0]              head_q, tail_q;
    logic [CNT_W-1:0]              occ_q;

    // The entry on the output is closed to merges
    assign lock_vec = ln_valid ? (ENTRIES'(1) << head_q) : '0;

    wbuf_tagmatch #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W)
    ) u_match (
        .vld_i     (slot_vld),
        .lock_i    (lock_vec),
        .tags_i    (slot_tag),
        .tag_q_i   (st_tag),
        .hit_vec_o (hit_vec),
        .hit_o     (st_hit)
    );

    wbuf_ctrl #(
        .ENTRIES (ENTRIES),
        .PTR_W   (PTR_W),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .st_hit     (st_hit),
        .flush_req  (flush_req),
        .ln_ready   (ln_ready),
        .st_ready   (st_ready),
        .ln_valid   (ln_valid),
        .flush_done (flush_done),
        .do_alloc   (do_alloc),
        .do_merge   (do_merge),
        .do_pop     (do_pop),
        .head_q     (head_q),
        .tail_q     (tail_q),
        .occ_q      (occ_q)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic alloc_i, merge_i, release_i;
        assign alloc_i   = do_alloc && (tail_q == PTR_W'(i));
        assign merge_i   = do_merge && hit_vec[i];
        assign release_i = do_pop   && (head_q == PTR_W'(i));

        wbuf_slot #(
            .TAG_W      (TAG_W),
            .LINE_BYTES (LINE_BYTES),
            .STRB_W     (STRB_W),
            .WIDX_W     (WIDX_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_i),
            .merge_i   (merge_i),
            .release_i (release_i),
            .tag_i     (st_tag),
            .widx_i    (st_widx),
            .data_i    (st_data),
            .strb_i    (st_strb),
            .vld_o     (slot_vld[i]),
            .tag_o     (slot_tag[i]),
            .line_o    (slot_line[i]),
            .mask_o    (slot_mask[i])
        );
    end

    assign ln_addr = slot_tag[head_q];
    assign ln_data = slot_line[head_q];
    assign ln_mask = slot_mask[head_q];
endmodule

// File: rtl/wbuf_coalesce_chk.sv
// Property checker, bound into the top module.
module wbuf_coalesce_chk #(
    parameter int TAG_W      = 27,
    parameter int LINE_BYTES = 32,
    parameter int ENTRIES    = 4,
    parameter int CNT_W      = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_ready,
    input logic                    ln_valid,
    input logic                    ln_ready,
    input logic [TAG_W-1:0]        ln_addr,
    input logic [LINE_BYTES*8-1:0] ln_data,
    input logic [LINE_BYTES-1:0]   ln_mask,
    input logic                    flush_done,
    input logic [CNT_W-1:0]        occ_q,
    input logic [ENTRIES-1:0]      hit_vec
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && !ln_ready) |=> (ln_valid && $stable(ln_addr) && $stable(ln_data) && $stable(ln_mask)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CNT_W'(ENTRIES));

    assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    assert_done_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (occ_q == '0 && !ln_valid && !st_ready));
endmodule

bind wbuf_coalesce wbuf_coalesce_chk #(
    .TAG_W      (TAG_W),
    .LINE_BYTES (LINE_BYTES),
    .ENTRIES    (ENTRIES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_ready   (st_ready),
    .ln_valid   (ln_valid),
    .ln_ready   (ln_ready),
    .ln_addr    (ln_addr),
    .ln_data    (ln_data),
    .ln_mask    (ln_mask),
    .flush_done (flush_done),
    .occ_q      (occ_q),
    .hit_vec    (hit_vec)
);

// File: tb/wbuf_coalesce_test.sv
module wbuf_coalesce_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LB = 32;
    localparam int NE = 4;
    localparam int SB = DW / 8;
    localparam int TW = AW - 5;
    localparam int LW = LB * 8;

    logic          clk, rst_n;
    logic          st_valid, st_ready;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [SB-1:0] st_strb;
    logic          ln_valid, ln_ready;
    logic [TW-1:0] ln_addr;
    logic [LW-1:0] ln_data;
    logic [LB-1:0] ln_mask;
    logic          flush_req, flush_done;

    wbuf_coalesce #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(LB), .ENTRIES(NE)) uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_strb(st_strb),
        .ln_valid(ln_valid), .ln_ready(ln_ready), .ln_addr(ln_addr),
        .ln_data(ln_data), .ln_mask(ln_mask),
        .flush_req(flush_req), .flush_done(flush_done)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct {
        logic [TW-1:0] tag;
        logic [LW-1:0] data;
        logic [LB-1:0] mask;
    } line_t;

    line_t mq[$];     // reference model entries, oldest first
    line_t wlog[$];   // line writes seen at the memory side
    int    ms;        // 0 fill, 1 drain, 2 flush, 3 done
    bit    mpend;
    int    n_checks, n_fail, cyc;

    // sampled at negedge, applied at posedge
    bit            s_ok, s_stfire, s_lnfire, s_flush, s_hold;
    int            s_hidx;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    logic [SB-1:0] s_strb;

    task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic line_t put_word(input line_t e, input logic [AW-1:0] a,
                                       input logic [DW-1:0] d, input logic [SB-1:0] s);
        line_t r = e;
        int w = int'(a[4:2]);
        for (int b = 0; b < SB; b++) begin
            if (s[b]) begin
                r.data[(w*SB+b)*8 +: 8] = d[b*8 +: 8];
                r.mask[w*SB+b] = 1'b1;
            end
        end
        return r;
    endfunction

    // Compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            bit lnv, rdy;
            int hidx;
            lnv  = (ms == 1) || (ms == 2 && mq.size() != 0);
            hidx = -1;
            for (int j = 0; j < mq.size(); j++)
                if (!(lnv && j == 0) && mq[j].tag == st_addr[AW-1:5]) hidx = j;
            rdy = (ms == 0 || ms == 1) && (hidx >= 0 || mq.size() < NE);
            chk("R7 st_ready", LW'(st_ready), LW'(rdy));
            chk("R5 ln_valid", LW'(ln_valid), LW'(lnv));
            chk("R10 flush_done", LW'(flush_done), LW'(ms == 3));
            if (s_hold) chk("R9 valid held", LW'(ln_valid), LW'(1));
            if (lnv) begin
                chk("R4 ln_addr", LW'(ln_addr), LW'(mq[0].tag));
                chk("R4 ln_data", ln_data, mq[0].data);
                chk("R3 ln_mask", LW'(ln_mask), LW'(mq[0].mask));
            end
            if (ln_valid && ln_ready) begin
                line_t r;
                r.tag = ln_addr; r.data = ln_data; r.mask = ln_mask;
                wlog.push_back(r);
            end
            s_ok     = 1'b1;
            s_stfire = st_valid && rdy;
            s_lnfire = lnv && ln_ready;
            s_hold   = lnv && !ln_ready;
            s_flush  = flush_req;
            s_hidx   = hidx;
            s_addr   = st_addr;
            s_data   = st_data;
            s_strb   = st_strb;
        end
    end

    // Advance the model
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            ms = 0; mpend = 1'b0; s_ok = 1'b0; s_hold = 1'b0;
        end else if (s_ok) begin
            int sz, nms;
            sz  = mq.size();
            nms = ms;
            case (ms)
                0: if (s_flush || mpend) nms = 2; else if (sz == NE) nms = 1;
                1: if (s_lnfire) nms = (s_flush || mpend) ? 2 : 0;
                2: if (sz == 0 || (s_lnfire && sz == 1)) nms = 3;
                default: nms = 0;
            endcase
            if (ms == 3) mpend = 1'b0; else if (s_flush) mpend = 1'b1;
            if (s_stfire) begin
                if (s_hidx >= 0) mq[s_hidx] = put_word(mq[s_hidx], s_addr, s_data, s_strb);
                else begin
                    line_t n;
                    n.tag = s_addr[AW-1:5]; n.data = '0; n.mask = '0;
                    mq.push_back(put_word(n, s_addr, s_data, s_strb));
                end
            end
            if (s_lnfire) void'(mq.pop_front());
            ms = nms;
            s_ok = 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [AW-1:0] la(input int tag, input int word);
        return (AW'(tag) << 5) | (AW'(word) << 2);
    endfunction

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SB-1:0] s);
        st_valid = 1'b1; st_addr = a; st_data = d; st_strb = s;
        forever begin
            @(negedge clk);
            if (st_ready) begin
                @(posedge clk); #1;
                break;
            end
            @(posedge clk); #1;
        end
        st_valid = 1'b0;
    endtask

    task automatic flush_wait(input int limit);
        flush_req = 1'b1;
        @(posedge clk); #1;
        flush_req = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (flush_done) begin
                @(posedge clk); #1;
                return;
            end
        end
        chk("R10 flush completes", LW'(0), LW'(1));
    endtask

    initial begin
        bit rnd_done;
        n_checks = 0; n_fail = 0; cyc = 0;
        rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_strb = '0;
        ln_ready = 1'b1; flush_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 st_ready", LW'(st_ready), LW'(1));
        chk("R1 ln_valid", LW'(ln_valid), LW'(0));
        chk("R1 flush_done", LW'(flush_done), LW'(0));
        @(posedge clk); #1;

        // R2/R3/R4: merge, byte overwrite, lane placement
        wlog.delete();
        store(la(5, 0), 32'h11223344, 4'hF);
        store(la(5, 0), 32'h0000AABB, 4'b0011);
        store(la(5, 7), 32'hCC000000, 4'b1000);
        flush_wait(20);
        chk("R2 one write", LW'(wlog.size()), LW'(1));
        if (wlog.size() == 1) begin
            chk("R3 mask", LW'(wlog[0].mask), LW'(32'h8000000F));
            chk("R3 overwrite", LW'(wlog[0].data[31:0]), LW'(32'h1122AABB));
            chk("R4 top byte", LW'(wlog[0].data[255:248]), LW'(8'hCC));
            chk("R3 zero fill", LW'(wlog[0].data[247:32]), LW'(0));
            chk("R4 tag", LW'(wlog[0].tag), LW'(5));
        end

        // R6: X, Y, Z with X/Z sharing a line
        wlog.delete();
        store(la(16, 1), 32'hA1A1A1A1, 4'hF);
        store(la(32, 0), 32'hB2B2B2B2, 4'hF);
        store(la(16, 2), 32'hC3C3C3C3, 4'hF);
        flush_wait(20);
        chk("R6 count", LW'(wlog.size()), LW'(2));
        if (wlog.size() == 2) begin
            chk("R6 first is merged line", LW'(wlog[0].tag), LW'(16));
            chk("R6 second", LW'(wlog[1].tag), LW'(32));
            chk("R6 merged mask", LW'(wlog[0].mask), LW'(32'h00000FF0));
        end

        // R5/R7/R8: capacity drain, full stall, head lock
        wlog.delete();
        ln_ready = 1'b0;
        for (int t = 1; t <= NE; t++) store(la(t, 0), 32'h01010101 * t, 4'hF);
        @(negedge clk);
        chk("R5 not yet draining", LW'(ln_valid), LW'(0));
        @(negedge clk);
        chk("R5 draining", LW'(ln_valid), LW'(1));
        chk("R5 oldest first", LW'(ln_addr), LW'(1));
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = la(1, 3); st_data = 32'hDEADBEEF; st_strb = 4'hF;
        @(negedge clk);
        chk("R8 head line stalls", LW'(st_ready), LW'(0));
        @(posedge clk); #1;
        st_addr = la(9, 0);
        @(negedge clk);
        chk("R7 new line stalls when full", LW'(st_ready), LW'(0));
        @(posedge clk); #1;
        st_addr = la(2, 1); st_data = 32'h55667788;
        @(negedge clk);
        chk("R7 hit accepted when full", LW'(st_ready), LW'(1));
        @(posedge clk); #1;
        st_valid = 1'b0;
        ln_ready = 1'b1;
        @(posedge clk); #1;
        ln_ready = 1'b0;
        store(la(1, 3), 32'hDEADBEEF, 4'hF);
        ln_ready = 1'b1;
        flush_wait(40);
        chk("R8 count", LW'(wlog.size()), LW'(5));
        if (wlog.size() == 5) begin
            chk("R5 order", LW'(wlog[1].tag), LW'(2));
            chk("R7 merged mask", LW'(wlog[1].mask), LW'(32'h000000FF));
            chk("R8 reopened line", LW'(wlog[4].tag), LW'(1));
            chk("R8 reopened mask", LW'(wlog[4].mask), LW'(32'h0000F000));
        end

        // R11/R10: flush requested during a stalled capacity drain
        wlog.delete();
        ln_ready = 1'b0;
        for (int t = 6; t < 6 + NE; t++) store(la(t, 2), 32'hF0F0F0F0, 4'hF);
        repeat (2) @(posedge clk);
        #1 flush_req = 1'b1;
        @(posedge clk); #1;
        flush_req = 1'b0;
        ln_ready = 1'b1;
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = la(8, 0); st_data = 32'h0; st_strb = 4'hF;
        @(negedge clk);
        chk("R10 stores refused in flush", LW'(st_ready), LW'(0));
        @(posedge clk); #1;
        st_valid = 1'b0;
        for (int i = 0; i < 20 && !flush_done; i++) @(negedge clk);
        chk("R11 flush finished", LW'(flush_done), LW'(1));
        @(posedge clk); #1;
        chk("R11 all drained", LW'(wlog.size()), LW'(NE));
        if (wlog.size() == NE) chk("R11 order", LW'(wlog[3].tag), LW'(9));

        // R10: flush of an empty buffer
        flush_req = 1'b1;
        @(posedge clk); #1;
        flush_req = 1'b0;
        @(negedge clk);
        chk("R10 empty flush cycle1", LW'(flush_done), LW'(0));
        @(negedge clk);
        chk("R10 empty flush cycle2", LW'(flush_done), LW'(1));
        @(posedge clk); #1;

        // Random traffic against the model
        rnd_done = 1'b0;
        fork
            begin
                for (int n = 0; n < 600; n++) begin
                    store(la($urandom_range(0, 5), $urandom_range(0, 7)), $urandom,
                          SB'($urandom_range(1, 15)));
                    if ($urandom_range(0, 39) == 0) flush_wait(200);
                end
                rnd_done = 1'b1;
            end
            begin
                while (!rnd_done) begin
                    ln_ready = ($urandom_range(0, 2) != 0);
                    @(posedge clk); #1;
                end
            end
        join
        ln_ready = 1'b1;
        flush_wait(40);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule